// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block holds the operand tags and valid bits for the decode, execute and memory stages of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It does not hold data values. Each cycle it takes the instruction in decode and checks three possible dependencies against the two older instructions ahead of it. The three are source 1, source 2 and the condition-code read. For each dependency it picks one of four outcomes: forward from the execute stage, forward from the memory stage, read the register file, or stall. The condition-code register is handled as a third operand. It follows the same rules as the registers.

The writeback stage is never compared. The register file is written in the first half of the cycle and read in the second, so writeback needs no forwarding. A load produces its result only at the end of the memory stage. A dependent instruction directly behind a load therefore waits one cycle and then takes the value from the memory stage. This applies to condition codes written by a load as well. A forwarding-enable input allows a machine without forwarding to be modelled. With it low, every match in execute or memory stalls until the producer reaches writeback.

During a stall, the decode latch keeps its contents and the upstream handshake is held off. The execute latch receives a bubble with every valid flag cleared. The forward selects are computed in decode and registered into the execute latch with the instruction they belong to. The execute-stage operand muxes therefore read them straight from a flop.

Top module: `hz_fwd_unit`

## Requirements
- R1: After a synchronous reset, `stall` is 0, `in_ready` is 1 and `ex_valid` is 0.
- R2: An operand whose valid flag is 0 (`in_src1_vld`, `in_src2_vld`, or `in_cc_rd` for the condition code) never causes a stall, and its select is 0 (register file), even if its register number matches an older destination.
- R3: A source matching the destination of a non-load instruction in execute gets select 1 (execute-stage forward) with no stall. Instructions of any non-load type forward this way.
- R4: A source matching the destination of a load in execute stalls decode for exactly one cycle. The instruction then leaves decode with select 2 (memory-stage forward).
- R5: A source matching a destination in the memory stage, load or not, gets select 2 with no stall while forwarding is enabled.
- R6: During a stall, `in_ready` is 0, the decode instruction is held, and execute receives a bubble (`ex_valid` 0). Each stall cycle shows up as one bubble in execute directly ahead of the stalled instruction.
- R7: When execute and memory both hold a matching destination, the younger producer in execute wins. A load in execute still stalls even if memory matches.
- R8: With `fwd_en` at 0, every match in execute or memory stalls. A consumer directly behind its producer stalls two cycles and then gets select 0.
- R9: A condition-code read (`in_cc_rd`) depends on an older condition-code write (`in_cc_wr`) under the R3 to R5 rules. This includes a load that writes condition codes, which forwards only from memory. The result is reported on `ex_sel_cc`.
- R10: A producer in writeback causes neither a stall nor a forward: select 0.
- R11: Source 1, source 2 and the condition code are resolved independently. Decode stalls if any one of them requires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 enables both forwarding paths, 0 turns every match into a stall |
| in_valid | input | 1 | An instruction from fetch is offered |
| in_tag | input | TAG_W | Identifier that travels with the instruction |
| in_src1_vld | input | 1 | Source 1 is used |
| in_src1 | input | REG_W | Source 1 register number |
| in_src2_vld | input | 1 | Source 2 is used |
| in_src2 | input | REG_W | Source 2 register number |
| in_dst_vld | input | 1 | Instruction writes a register |
| in_dst | input | REG_W | Destination register number |
| in_is_load | input | 1 | Instruction is a load (result ready after memory) |
| in_cc_rd | input | 1 | Instruction reads condition codes (branch) |
| in_cc_wr | input | 1 | Instruction writes condition codes |
| in_ready | output | 1 | Offered instruction is taken at this edge (not stalled) |
| stall | output | 1 | Decode is stalled this cycle |
| ex_valid | output | 1 | Execute stage holds an instruction, 0 for a bubble |
| ex_tag | output | TAG_W | Identifier of the instruction in execute |
| ex_sel_src1 | output | 2 | Source 1 select: 0 register file, 1 from execute, 2 from memory |
| ex_sel_src2 | output | 2 | Source 2 select, same encoding |
| ex_sel_cc | output | 2 | Condition-code select, same encoding |

## Verification
The hardest situation to reach is the one where the younger and the older in-flight instructions both write the register a consumer reads. When the younger of the two is a load, decode must stall and then take the load's value from memory, not the stale value from the older instruction. Reaching this needs three instructions issued back to back, with no idle cycle that would let the older producer drain. The driver therefore issues whole dependency chains without gaps, and the monitor checks the number of bubbles ahead of each instruction as well as its selects. The same back-to-back chains are replayed for condition codes and with forwarding disabled, where the two-cycle stall must end with a register-file read.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int REG_W = 5;
  parameter int TAG_W = 8;
  localparam int NOPS = 3;      // 0: source 1, 1: source 2, 2: condition codes
  localparam int NREG_OPS = 2;  // operands compared against register destinations

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2
  } fsel_e;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             s1_v;
    logic [REG_W-1:0] s1;
    logic             s2_v;
    logic [REG_W-1:0] s2;
    logic             d_v;
    logic [REG_W-1:0] d;
    logic             ld;
    logic             cc_rd;
    logic             cc_wr;
  } uop_t;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             d_v;
    logic [REG_W-1:0] d;
    logic             ld;
    logic             cc_wr;
  } prod_t;
endpackage

// File: rtl/hz_operand_resolve.sv
module hz_operand_resolve
  import hz_pkg::*;
(
  input  logic  need,
  input  logic  ex_hit,
  input  logic  ex_late,
  input  logic  mem_hit,
  input  logic  fwd_en,
  output fsel_e sel,
  output logic  stall_req
);
  // Younger producer (execute) is checked first.
  always_comb begin
    sel       = SEL_RF;
    stall_req = 1'b0;
    if (need) begin
      if (ex_hit) begin
        if (fwd_en && !ex_late) sel = SEL_EX;
        else                    stall_req = 1'b1;
      end else if (mem_hit) begin
        if (fwd_en) sel = SEL_MEM;
        else        stall_req = 1'b1;
      end
    end
  end

  always_comb begin
    if (!need) assert (sel == SEL_RF && !stall_req);
  end
endmodule

// File: rtl/hz_stage_latches.sv
module hz_stage_latches
  import hz_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stall,
  input  logic  in_valid,
  input  uop_t  in_uop,
  input  fsel_e dec_sel [NOPS],
  output uop_t  id_q,
  output prod_t ex_q,
  output fsel_e ex_sel_q [NOPS],
  output prod_t mem_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q <= '0;
    end else if (!stall) begin
      id_q       <= in_uop;
      id_q.valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      ex_q <= '0;
    end else begin
      ex_q.valid <= id_q.valid;
      ex_q.tag   <= id_q.tag;
      ex_q.d_v   <= id_q.d_v;
      ex_q.d     <= id_q.d;
      ex_q.ld    <= id_q.ld;
      ex_q.cc_wr <= id_q.cc_wr;
    end
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst || stall) ex_sel_q[k] <= SEL_RF;
      else              ex_sel_q[k] <= dec_sel[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mem_q <= '0;
    else     mem_q <= ex_q;
  end

  assert_bubble_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ex_q.valid);
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(id_q));
  assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (!stall && id_q.valid) |=> (ex_q.valid && ex_q.tag == $past(id_q.tag)));
  assert_mem_follows_ex_R6: assert property (@(posedge clk) disable iff (rst)
    ex_q.valid |=> (mem_q.valid && mem_q.tag == $past(ex_q.tag)));
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_en,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_src1_vld,
  input  logic [REG_W-1:0] in_src1,
  input  logic             in_src2_vld,
  input  logic [REG_W-1:0] in_src2,
  input  logic             in_dst_vld,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_is_load,
  input  logic             in_cc_rd,
  input  logic             in_cc_wr,
  output logic             in_ready,
  output logic             stall,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic [1:0]       ex_sel_src1,
  output logic [1:0]       ex_sel_src2,
  output logic [1:0]       ex_sel_cc
);
  uop_t  in_uop, id_q;
  prod_t ex_q, mem_q;
  fsel_e dec_sel  [NOPS];
  fsel_e ex_sel_q [NOPS];
  logic  [NOPS-1:0] need, ex_hit, mem_hit, stall_req;
  logic  [REG_W-1:0] src_reg [NREG_OPS];
  logic  [NREG_OPS-1:0] src_vld;

  always_comb begin
    in_uop       = '0;
    in_uop.valid = in_valid;
    in_uop.tag   = in_tag;
    in_uop.s1_v  = in_src1_vld;
    in_uop.s1    = in_src1;
    in_uop.s2_v  = in_src2_vld;
    in_uop.s2    = in_src2;
    in_uop.d_v   = in_dst_vld;
    in_uop.d     = in_dst;
    in_uop.ld    = in_is_load;
    in_uop.cc_rd = in_cc_rd;
    in_uop.cc_wr = in_cc_wr;
  end

  assign src_reg[0] = id_q.s1;
  assign src_reg[1] = id_q.s2;
  assign src_vld[0] = id_q.s1_v;
  assign src_vld[1] = id_q.s2_v;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    if (k < NREG_OPS) begin : g_reg
      assign need[k]    = id_q.valid && src_vld[k];
      assign ex_hit[k]  = ex_q.valid && ex_q.d_v && (ex_q.d == src_reg[k]);
      assign mem_hit[k] = mem_q.valid && mem_q.d_v && (mem_q.d == src_reg[k]);
    end else begin : g_cc
      assign need[k]    = id_q.valid && id_q.cc_rd;
      assign ex_hit[k]  = ex_q.valid && ex_q.cc_wr;
      assign mem_hit[k] = mem_q.valid && mem_q.cc_wr;
    end

    hz_operand_resolve u_res (
      .need      (need[k]),
      .ex_hit    (ex_hit[k]),
      .ex_late   (ex_q.ld),
      .mem_hit   (mem_hit[k]),
      .fwd_en    (fwd_en),
      .sel       (dec_sel[k]),
      .stall_req (stall_req[k])
    );

    // A consumer forwarded from execute must have a non-load producer, now in memory.
    assert_load_not_from_ex_R4: assert property (@(posedge clk) disable iff (rst)
      (ex_q.valid && ex_sel_q[k] == SEL_EX) |-> (mem_q.valid && !mem_q.ld));
    assert_sel_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
      ex_sel_q[k] != fsel_e'(2'd3));
  end

  assign stall    = |stall_req;
  assign in_ready = !stall;

  hz_stage_latches u_lat (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .in_valid (in_valid),
    .in_uop   (in_uop),
    .dec_sel  (dec_sel),
    .id_q     (id_q),
    .ex_q     (ex_q),
    .ex_sel_q (ex_sel_q),
    .mem_q    (mem_q)
  );

  assign ex_valid    = ex_q.valid;
  assign ex_tag      = ex_q.tag;
  assign ex_sel_src1 = ex_sel_q[0];
  assign ex_sel_src2 = ex_sel_q[1];
  assign ex_sel_cc   = ex_sel_q[2];

  assert_no_fwd_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !$past(fwd_en)) |->
      (ex_sel_src1 == 2'd0 && ex_sel_src2 == 2'd0 && ex_sel_cc == 2'd0));
  assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    !id_q.valid |-> !stall);
endmodule

// File: tb/hz_fwd_unit_tb_top.sv
`timescale 1ns/1ps
module hz_fwd_unit_tb_top;
  import hz_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en = 1'b1;
  logic in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic in_src1_vld = 1'b0, in_src2_vld = 1'b0, in_dst_vld = 1'b0;
  logic [REG_W-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic in_is_load = 1'b0, in_cc_rd = 1'b0, in_cc_wr = 1'b0;
  logic in_ready, stall, ex_valid;
  logic [TAG_W-1:0] ex_tag;
  logic [1:0] ex_sel_src1, ex_sel_src2, ex_sel_cc;

  always #2 clk = ~clk;

  hz_fwd_unit dut_i (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .in_valid(in_valid), .in_tag(in_tag),
    .in_src1_vld(in_src1_vld), .in_src1(in_src1), .in_src2_vld(in_src2_vld),
    .in_src2(in_src2), .in_dst_vld(in_dst_vld), .in_dst(in_dst),
    .in_is_load(in_is_load), .in_cc_rd(in_cc_rd), .in_cc_wr(in_cc_wr),
    .in_ready(in_ready), .stall(stall), .ex_valid(ex_valid), .ex_tag(ex_tag),
    .ex_sel_src1(ex_sel_src1), .ex_sel_src2(ex_sel_src2), .ex_sel_cc(ex_sel_cc)
  );

  typedef struct {
    int    tag;
    int    s1, s2, cc;
    int    gap;   // bubbles expected right ahead of it, -1 = not checked
    string req;
  } exp_t;
  exp_t  sb_q[$];
  int    n_cmp = 0, n_bad = 0;
  int    bubbles = 0;
  bit    done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compare each instruction leaving decode with the scoreboard.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ex_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R6", "unexpected instruction in execute, tag", int'(ex_tag), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(ex_tag) == e.tag, e.req, "tag", int'(ex_tag), e.tag);
          check(int'(ex_sel_src1) == e.s1, e.req, "src1 select", int'(ex_sel_src1), e.s1);
          check(int'(ex_sel_src2) == e.s2, e.req, "src2 select", int'(ex_sel_src2), e.s2);
          check(int'(ex_sel_cc) == e.cc, e.req, "cc select", int'(ex_sel_cc), e.cc);
          if (e.gap >= 0)
            check(bubbles == e.gap, {e.req, " R6"}, "bubbles ahead", bubbles, e.gap);
        end
        bubbles = 0;
      end else begin
        bubbles++;
      end
    end
  end

  // Driver: tasks start and end at a falling edge.
  task automatic issue(int tag, bit s1v, int s1, bit s2v, int s2, bit dv, int d,
                       bit ld, bit ccr, bit ccw, int e1, int e2, int ec, int gap,
                       string req);
    exp_t e;
    bit acc;
    e.tag = tag; e.s1 = e1; e.s2 = e2; e.cc = ec; e.gap = gap; e.req = req;
    sb_q.push_back(e);
    in_valid = 1'b1; in_tag = TAG_W'(tag);
    in_src1_vld = s1v; in_src1 = REG_W'(s1);
    in_src2_vld = s2v; in_src2 = REG_W'(s2);
    in_dst_vld = dv; in_dst = REG_W'(d);
    in_is_load = ld; in_cc_rd = ccr; in_cc_wr = ccw;
    while (1) begin
      acc = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(stall == 1'b0, "R1", "stall", int'(stall), 0);
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    check(ex_valid == 1'b0, "R1", "ex_valid", int'(ex_valid), 0);

    // Forwarding on: basic chain
    issue(1, 0,0, 0,0, 1,1, 0,0,0, 0,0,0, -1, "R3");
    issue(2, 1,1, 1,2, 1,3, 0,0,0, 1,0,0,  0, "R3");    // r1 from execute
    issue(3, 1,1, 1,3, 1,4, 0,0,0, 2,1,0,  0, "R5 R11"); // r1 from memory, r3 from execute
    issue(4, 0,4, 1,1, 1,5, 1,0,0, 0,0,0,  0, "R2 R10"); // r4 flag off, r1 in writeback
    issue(5, 1,5, 0,0, 1,6, 0,0,0, 2,0,0,  1, "R4");    // behind load: 1 stall
    idle(4);

    // Younger producer wins
    issue(6, 0,0, 0,0, 1,7, 0,0,0, 0,0,0, -1, "R7");
    issue(7, 0,0, 0,0, 1,7, 0,0,0, 0,0,0,  0, "R7");
    issue(8, 1,7, 0,0, 1,9, 0,0,0, 1,0,0,  0, "R7");
    idle(4);
    issue(9,  0,0, 0,0, 1,8, 0,0,0, 0,0,0, -1, "R7");
    issue(10, 0,0, 0,0, 1,8, 1,0,0, 0,0,0,  0, "R7");   // load, same register
    issue(11, 1,12, 1,8, 1,13, 0,0,0, 0,2,0, 1, "R7 R4 R11");
    idle(4);

    // Condition codes
    issue(12, 0,0, 0,0, 0,0, 0,0,1, 0,0,0, -1, "R9");
    issue(13, 0,0, 0,0, 0,0, 0,1,0, 0,0,1,  0, "R9");
    issue(14, 0,0, 0,0, 1,14, 1,0,1, 0,0,0, 0, "R9");   // load writing cc
    issue(15, 0,0, 0,0, 0,0, 0,1,0, 0,0,2,  1, "R9");
    issue(16, 0,0, 0,0, 0,0, 0,1,0, 0,0,0,  0, "R9 R10");
    issue(17, 0,0, 0,0, 0,0, 0,0,1, 0,0,0,  0, "R2");
    issue(18, 0,0, 0,0, 0,0, 0,0,0, 0,0,0,  0, "R2");   // cc read flag off
    idle(4);

    // Forwarding disabled
    fwd_en = 1'b0;
    idle(1);
    issue(19, 0,0, 0,0, 1,10, 0,0,0, 0,0,0, -1, "R8");
    issue(20, 1,10, 0,0, 1,11, 0,0,0, 0,0,0, 2, "R8");
    issue(21, 0,0, 1,10, 0,0, 0,0,0, 0,0,0,  0, "R8 R10");
    issue(22, 1,20, 1,21, 0,0, 0,0,0, 0,0,0, 0, "R8");
    issue(23, 0,0, 0,0, 0,0, 0,1,0, 0,0,0,  0, "R8");
    idle(6);

    check(sb_q.size() == 0, "R6", "instructions never reached execute", sb_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule